// File: doc/BRIEF.md
# External Bus Phase Sequencer

This block runs one read or write transfer at a time on an external memory or peripheral bus. An internal master supplies a request with an address, a direction flag, write data and a chip-select index. The sequencer then walks the transfer through six phases in a fixed order. Each phase lasts a programmable whole number of clock periods. While the transfer runs, the block drives the active-low chip selects, the address, an address latch enable, active-low read and write strobes, and the data bus. The data bus is modelled as a separate output value, an output enable and an input value.

The six phases are, in order:

- a turnaround phase that keeps the data drivers off, used only when the chip select changes;
- an address phase during which the latch enable is high;
- a command delay;
- a write-data setup phase;
- the strobe phase;
- a hold phase.

The bus has four modes: 8 or 16 data bits, each with either separate address and data lines or shared lines. In shared mode, the low address bits travel on the data lines during the address phase. Read data is captured on the clock edge that ends the strobe phase. A one-cycle completion pulse follows the hold phase. Phase lengths outside their legal range are clamped, and a configuration error flag is raised. Configuration is sampled when a request is accepted.

Top module: `busPhaseSeq`

## Requirements
- R1: Phase lengths in clock cycles take effect after clamping. The phase order is turnaround (T), address (B), command delay (C), write setup (D), strobe (E), hold (F). A phase of length zero is skipped. The transfer occupies exactly the sum of the lengths, starting in the cycle after the accepting edge.
- R2: The turnaround phase lasts cfgLenA cycles only when reqCs differs from the chip select of the previous transfer, or when no transfer has run since reset. Otherwise it lasts zero cycles.
- R3: During every phase, exactly busCsN[reqCs] is low and busAddr equals the accepted address. When idle, all busCsN bits are high.
- R4: busAle is high exactly during the turnaround and address phases, and low otherwise, including when idle.
- R5: During the strobe phase, busRdN is low on a read and busWrN is low on a write (reqWrite=1). Both strobes are high at all other times.
- R6: On a write, busDataOe is high and busDataOut carries the write data from the write-setup phase through the hold phase. busDataOe is low in the turnaround and command-delay phases, and on reads outside the address phase.
- R7: With cfgMux=1, busDataOe is high during the address phase and busDataOut carries the low address bits. With cfgMux=0, busDataOe is low during the address phase.
- R8: rdData takes the value of busDataIn present at the clock edge that ends the strobe phase of a read. rdData holds that value until the next read.
- R9: With cfgWide=1, busBheN is low during the transfer, and both the address and data values on busDataOut are 16 bits. With cfgWide=0, busBheN stays high, bits 15:8 of busDataOut and rdData are zero, and only bits 7:0 carry data.
- R10: Lengths are clamped as follows: the address phase to 1..2, the write-setup phase to 0..1 and the strobe phase to 1..32. cfgErr is set for a transfer exactly when one of these three was out of range. It is updated at acceptance and holds until the next acceptance.
- R11: busy is high from the accepting edge until the last phase ends. done is high for exactly the one cycle after that. A request seen while busy is ignored.
- R12: After reset, busy, done, cfgErr and busAle are low, the strobes and all chip selects are high, and busDataOe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Transfer request, accepted only when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqCs | input | $clog2(CS_NUM) | Chip-select index |
| reqAddr | input | ADDR_W | Transfer address |
| reqWdata | input | DATA_W | Write data |
| cfgMux | input | 1 | 1 = shared address/data lines |
| cfgWide | input | 1 | 1 = 16-bit data, 0 = 8-bit |
| cfgLenA | input | SHORT_W | Turnaround phase length |
| cfgLenB | input | SHORT_W | Address phase length |
| cfgLenC | input | SHORT_W | Command delay length |
| cfgLenD | input | SHORT_W | Write setup length |
| cfgLenE | input | ELEN_W | Strobe phase length |
| cfgLenF | input | SHORT_W | Hold phase length |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| cfgErr | output | 1 | A length of the last accepted transfer was clamped |
| rdData | output | DATA_W | Captured read data |
| busCsN | output | CS_NUM | Active-low chip selects |
| busAddr | output | ADDR_W | Address lines |
| busBheN | output | 1 | Active-low byte-high enable |
| busAle | output | 1 | Address latch enable |
| busRdN | output | 1 | Active-low read strobe |
| busWrN | output | 1 | Active-low write strobe |
| busDataOut | output | DATA_W | Data bus output value |
| busDataOe | output | 1 | Data bus output enable |
| busDataIn | input | DATA_W | Data bus input value |

## Verification
The assertions assume that reset is asserted before the first edge. They also assume that request and configuration inputs change only between clock edges. They assume nothing about the length inputs, because every raw value is clamped. The stimulus therefore draws lengths from their full field ranges, including the illegal ones. It changes every input only on the falling clock edge. It also raises req in the middle of a transfer, so that the ignore path stays within what the properties describe.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_A    = 3'd1,
    PH_B    = 3'd2,
    PH_C    = 3'd3,
    PH_D    = 3'd4,
    PH_E    = 3'd5,
    PH_F    = 3'd6
  } phase_t;

  localparam int NUM_PHASES = 6;

  typedef struct packed {
    phase_t phase;
    logic   load;
    logic   capture;
  } ctrl_strobe_t;

endpackage

// File: rtl/busseq_dpath.sv
module busseq_dpath
  import busseq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int CS_NUM = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrl_strobe_t               strb,
  input  logic                       reqWrite,
  input  logic [$clog2(CS_NUM)-1:0]  reqCs,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic [DATA_W-1:0]          reqWdata,
  input  logic                       cfgMux,
  input  logic                       cfgWide,
  input  logic [DATA_W-1:0]          busDataIn,
  output logic [DATA_W-1:0]          rdData,
  output logic [CS_NUM-1:0]          busCsN,
  output logic [ADDR_W-1:0]          busAddr,
  output logic                       busBheN,
  output logic                       busAle,
  output logic                       busRdN,
  output logic                       busWrN,
  output logic [DATA_W-1:0]          busDataOut,
  output logic                       busDataOe
);

  localparam int CS_W = $clog2(CS_NUM);
  localparam int HALF = DATA_W / 2;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdQ;
  logic [CS_W-1:0]   csQ;
  logic              writeQ;
  logic              muxQ;
  logic              wideQ;

  // Narrow mode keeps only the low byte lane.
  function automatic logic [DATA_W-1:0] fitLane(input logic [DATA_W-1:0] v, input logic wide);
    return wide ? v : {{(DATA_W-HALF){1'b0}}, v[HALF-1:0]};
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdQ    <= '0;
      csQ    <= '0;
      writeQ <= 1'b0;
      muxQ   <= 1'b0;
      wideQ  <= 1'b0;
    end else begin
      if (strb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        csQ    <= reqCs;
        writeQ <= reqWrite;
        muxQ   <= cfgMux;
        wideQ  <= cfgWide;
      end
      if (strb.capture && !writeQ) begin
        rdQ <= fitLane(busDataIn, wideQ);
      end
    end
  end

  logic active;
  logic addrDrive;
  logic dataDrive;

  always_comb begin
    active    = (strb.phase != PH_IDLE);
    addrDrive = (strb.phase == PH_B) && muxQ;
    dataDrive = writeQ && ((strb.phase == PH_D) || (strb.phase == PH_E) ||
                           (strb.phase == PH_F));
  end

  for (genvar i = 0; i < CS_NUM; i++) begin : g_cs
    assign busCsN[i] = !(active && (csQ == CS_W'(i)));
  end

  assign busAddr   = addrQ;
  assign busBheN   = !(active && wideQ);
  assign busAle    = (strb.phase == PH_A) || (strb.phase == PH_B);
  assign busRdN    = !((strb.phase == PH_E) && !writeQ);
  assign busWrN    = !((strb.phase == PH_E) && writeQ);
  assign busDataOe = addrDrive || dataDrive;
  assign busDataOut = addrDrive ? fitLane(addrQ[DATA_W-1:0], wideQ) :
                      dataDrive ? fitLane(wdataQ, wideQ) : '0;
  assign rdData    = rdQ;

endmodule

// File: rtl/busseq_ctrl.sv
module busseq_ctrl
  import busseq_pkg::*;
#(
  parameter int CS_NUM  = 4,
  parameter int SHORT_W = 2,
  parameter int ELEN_W  = 6,
  parameter int E_MAX   = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       req,
  input  logic [$clog2(CS_NUM)-1:0]  reqCs,
  input  logic [SHORT_W-1:0]         cfgLenA,
  input  logic [SHORT_W-1:0]         cfgLenB,
  input  logic [SHORT_W-1:0]         cfgLenC,
  input  logic [SHORT_W-1:0]         cfgLenD,
  input  logic [ELEN_W-1:0]          cfgLenE,
  input  logic [SHORT_W-1:0]         cfgLenF,
  output ctrl_strobe_t               strb,
  output logic                       busy,
  output logic                       done,
  output logic                       cfgErr
);

  localparam int CS_W  = $clog2(CS_NUM);
  localparam int CNT_W = ELEN_W;
  localparam int SHORT_MAX = (1 << SHORT_W) - 1;
  localparam int MINL [NUM_PHASES] = '{0, 1, 0, 0, 1, 0};
  localparam int MAXL [NUM_PHASES] = '{SHORT_MAX, 2, SHORT_MAX, 1, E_MAX, SHORT_MAX};

  phase_t           state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] rawLen [NUM_PHASES];
  logic [CNT_W-1:0] clmLen [NUM_PHASES];
  logic [CNT_W-1:0] lenNew [NUM_PHASES];
  logic [CNT_W-1:0] lenQ   [NUM_PHASES];
  logic [CNT_W-1:0] srcLen [NUM_PHASES];
  logic [NUM_PHASES-1:0] errBit;
  logic [CS_W-1:0]  lastCs;
  logic             lastValid;
  logic             csChange;
  logic             idle;
  phase_t           nxtPh;
  logic [CNT_W-1:0] nxtCnt;
  int               startIdx;

  assign rawLen[0] = CNT_W'(cfgLenA);
  assign rawLen[1] = CNT_W'(cfgLenB);
  assign rawLen[2] = CNT_W'(cfgLenC);
  assign rawLen[3] = CNT_W'(cfgLenD);
  assign rawLen[4] = cfgLenE;
  assign rawLen[5] = CNT_W'(cfgLenF);

  // Clamp each raw length into its legal window.
  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_clamp
    always_comb begin
      if (rawLen[g] < CNT_W'(MINL[g])) begin
        clmLen[g] = CNT_W'(MINL[g]);
        errBit[g] = 1'b1;
      end else if (rawLen[g] > CNT_W'(MAXL[g])) begin
        clmLen[g] = CNT_W'(MAXL[g]);
        errBit[g] = 1'b1;
      end else begin
        clmLen[g] = rawLen[g];
        errBit[g] = 1'b0;
      end
    end
  end

  assign idle     = (state == PH_IDLE);
  assign csChange = !lastValid || (reqCs != lastCs);

  always_comb begin
    for (int j = 0; j < NUM_PHASES; j++) begin
      lenNew[j] = clmLen[j];
    end
    if (!csChange) lenNew[0] = '0;
    for (int j = 0; j < NUM_PHASES; j++) begin
      srcLen[j] = idle ? lenNew[j] : lenQ[j];
    end
    startIdx = idle ? 0 : int'(state);
  end

  // Find the first non-empty phase at or after startIdx.
  always_comb begin
    nxtPh  = PH_IDLE;
    nxtCnt = '0;
    for (int j = NUM_PHASES - 1; j >= 0; j--) begin
      if ((j >= startIdx) && (srcLen[j] != '0)) begin
        nxtPh  = phase_t'(3'(j + 1));
        nxtCnt = srcLen[j] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= PH_IDLE;
      cnt       <= '0;
      done      <= 1'b0;
      cfgErr    <= 1'b0;
      lastCs    <= '0;
      lastValid <= 1'b0;
      for (int j = 0; j < NUM_PHASES; j++) lenQ[j] <= '0;
    end else begin
      done <= 1'b0;
      if (idle) begin
        if (req) begin
          state     <= nxtPh;
          cnt       <= nxtCnt;
          cfgErr    <= |errBit;
          lastCs    <= reqCs;
          lastValid <= 1'b1;
          for (int j = 0; j < NUM_PHASES; j++) lenQ[j] <= lenNew[j];
        end
      end else if (cnt == '0) begin
        state <= nxtPh;
        cnt   <= nxtCnt;
        if (nxtPh == PH_IDLE) done <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign busy         = !idle;
  assign strb.phase   = state;
  assign strb.load    = idle && req;
  assign strb.capture = (state == PH_E) && (cnt == '0);

endmodule

// File: rtl/busPhaseSeq.sv
module busPhaseSeq
  import busseq_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int CS_NUM  = 4,
  parameter int SHORT_W = 2,
  parameter int ELEN_W  = 6,
  parameter int E_MAX   = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       req,
  input  logic                       reqWrite,
  input  logic [$clog2(CS_NUM)-1:0]  reqCs,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic [DATA_W-1:0]          reqWdata,
  input  logic                       cfgMux,
  input  logic                       cfgWide,
  input  logic [SHORT_W-1:0]         cfgLenA,
  input  logic [SHORT_W-1:0]         cfgLenB,
  input  logic [SHORT_W-1:0]         cfgLenC,
  input  logic [SHORT_W-1:0]         cfgLenD,
  input  logic [ELEN_W-1:0]          cfgLenE,
  input  logic [SHORT_W-1:0]         cfgLenF,
  output logic                       busy,
  output logic                       done,
  output logic                       cfgErr,
  output logic [DATA_W-1:0]          rdData,
  output logic [CS_NUM-1:0]          busCsN,
  output logic [ADDR_W-1:0]          busAddr,
  output logic                       busBheN,
  output logic                       busAle,
  output logic                       busRdN,
  output logic                       busWrN,
  output logic [DATA_W-1:0]          busDataOut,
  output logic                       busDataOe,
  input  logic [DATA_W-1:0]          busDataIn
);

  ctrl_strobe_t strb;

  busseq_ctrl #(
    .CS_NUM(CS_NUM), .SHORT_W(SHORT_W), .ELEN_W(ELEN_W), .E_MAX(E_MAX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .req(req), .reqCs(reqCs),
    .cfgLenA(cfgLenA), .cfgLenB(cfgLenB), .cfgLenC(cfgLenC),
    .cfgLenD(cfgLenD), .cfgLenE(cfgLenE), .cfgLenF(cfgLenF),
    .strb(strb), .busy(busy), .done(done), .cfgErr(cfgErr)
  );

  busseq_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CS_NUM(CS_NUM)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqWrite(reqWrite), .reqCs(reqCs), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .cfgMux(cfgMux), .cfgWide(cfgWide), .busDataIn(busDataIn),
    .rdData(rdData), .busCsN(busCsN), .busAddr(busAddr), .busBheN(busBheN),
    .busAle(busAle), .busRdN(busRdN), .busWrN(busWrN),
    .busDataOut(busDataOut), .busDataOe(busDataOe)
  );

endmodule

// File: rtl/busseq_chk.sv
module busseq_chk #(
  parameter int CS_NUM = 4,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              cfgErr,
  input logic [CS_NUM-1:0] busCsN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busAle,
  input logic              busRdN,
  input logic              busWrN,
  input logic              busDataOe
);

  a_r3_cs_single: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ($countones(~busCsN) == 1));

  a_r3_cs_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (&busCsN));

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(busAddr));

  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({~busRdN, ~busWrN}));

  a_r4_ale_quiet: assert property (@(posedge clk) disable iff (!rstN)
    busAle |-> (busRdN && busWrN));

  a_r6_read_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    !busRdN |-> !busDataOe);

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r11_done_on_finish: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r10_err_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(cfgErr));

endmodule

bind busPhaseSeq busseq_chk #(.CS_NUM(CS_NUM), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_busPhaseSeq.sv
`timescale 1ns/1ps
module sim_busPhaseSeq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqCs = '0;
  logic [23:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        cfgMux = 1'b0;
  logic        cfgWide = 1'b1;
  logic [1:0]  cfgLenA = '0, cfgLenB = 2'd1, cfgLenC = '0, cfgLenD = '0, cfgLenF = '0;
  logic [5:0]  cfgLenE = 6'd1;
  logic        busy, done, cfgErr;
  logic [15:0] rdData;
  logic [3:0]  busCsN;
  logic [23:0] busAddr;
  logic        busBheN, busAle, busRdN, busWrN;
  logic [15:0] busDataOut;
  logic        busDataOe;
  logic [15:0] busDataIn = '0;

  int checks = 0;
  int failures = 0;
  bit lastValidB = 0;
  int lastCsB = 0;

  always #5 clk = ~clk;

  busPhaseSeq u0 (
    .clk(clk), .rstN(rstN), .req(req), .reqWrite(reqWrite), .reqCs(reqCs),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .cfgMux(cfgMux), .cfgWide(cfgWide),
    .cfgLenA(cfgLenA), .cfgLenB(cfgLenB), .cfgLenC(cfgLenC), .cfgLenD(cfgLenD),
    .cfgLenE(cfgLenE), .cfgLenF(cfgLenF), .busy(busy), .done(done), .cfgErr(cfgErr),
    .rdData(rdData), .busCsN(busCsN), .busAddr(busAddr), .busBheN(busBheN),
    .busAle(busAle), .busRdN(busRdN), .busWrN(busWrN), .busDataOut(busDataOut),
    .busDataOe(busDataOe), .busDataIn(busDataIn)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int clampL(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic logic [15:0] lane(input logic [15:0] v, input bit wide);
    return wide ? v : {8'h00, v[7:0]};
  endfunction

  task automatic runTxn(input bit wr, input int cs, input logic [23:0] addr,
                        input logic [15:0] wd, input bit mux, input bit wide,
                        input int a, input int b, input int c, input int d,
                        input int e, input int f, input bit inject);
    int expLen [6];
    bit expErr;
    logic [3:0] expCs;
    logic [15:0] expRd;
    logic [15:0] expOut;
    bit expAle, expRdN, expWrN, expOe;
    expLen[0] = (!lastValidB || cs != lastCsB) ? a : 0;
    expLen[1] = clampL(b, 1, 2);
    expLen[2] = c;
    expLen[3] = clampL(d, 0, 1);
    expLen[4] = clampL(e, 1, 32);
    expLen[5] = f;
    expErr = (b < 1) || (b > 2) || (d > 1) || (e < 1) || (e > 32);
    expCs = ~(4'b0001 << cs);
    expRd = rdData;
    lastValidB = 1;
    lastCsB = cs;
    reqWrite = wr; reqCs = 2'(cs); reqAddr = addr; reqWdata = wd;
    cfgMux = mux; cfgWide = wide;
    cfgLenA = 2'(a); cfgLenB = 2'(b); cfgLenC = 2'(c); cfgLenD = 2'(d);
    cfgLenE = 6'(e); cfgLenF = 2'(f);
    req = 1'b1;
    for (int p = 0; p < 6; p++) begin
      for (int k = 0; k < expLen[p]; k++) begin
        @(negedge clk);
        if (p == 0 && k == 0 && expLen[0] == 0) begin end
        // Request handling: ignored while busy (R11)
        if (inject && req && reqCs == 2'(cs)) begin
          reqCs = 2'(cs + 1); reqAddr = ~addr; cfgLenE = 6'd3;
        end else begin
          req = 1'b0;
        end
        expAle = (p <= 1);
        expRdN = !(p == 4 && !wr);
        expWrN = !(p == 4 && wr);
        expOe  = (p == 1 && mux) || (wr && p >= 3);
        expOut = (p == 1) ? lane(addr[15:0], wide) : lane(wd, wide);
        chk(busCsN == expCs, "R3 chip select", 64'(busCsN), 64'(expCs));
        chk(busAddr == addr, "R3 address hold", 64'(busAddr), 64'(addr));
        chk(busAle == expAle, "R2/R4 latch enable per phase", 64'(busAle), 64'(expAle));
        chk(busRdN == expRdN && busWrN == expWrN, "R5 strobes",
            64'({busRdN, busWrN}), 64'({expRdN, expWrN}));
        chk(busDataOe == expOe, "R6/R7 data output enable", 64'(busDataOe), 64'(expOe));
        if (expOe)
          chk(busDataOut == expOut, "R6/R7/R9 data bus value", 64'(busDataOut), 64'(expOut));
        chk(busBheN == !wide, "R9 byte-high enable", 64'(busBheN), 64'(!wide));
        chk(busy && !done, "R1/R11 busy during phases", 64'({busy, done}), 64'(2'b10));
        busDataIn = 16'($urandom);
        if (p == 4 && k == expLen[4] - 1 && !wr) expRd = lane(busDataIn, wide);
      end
    end
    @(negedge clk);
    req = 1'b0;
    chk(done && !busy, "R1/R11 done pulse after last phase", 64'({done, busy}), 64'(2'b10));
    chk(busCsN == 4'hF && busAle == 1'b0, "R3/R4 idle bus after transfer",
        64'({busCsN, busAle}), 64'({4'hF, 1'b0}));
    chk(rdData == expRd, "R8 captured read data", 64'(rdData), 64'(expRd));
    chk(cfgErr == expErr, "R10 clamp flag", 64'(cfgErr), 64'(expErr));
  endtask

  initial begin
    void'($urandom(32'd20241));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cfgErr, "R12 reset status", 64'({busy, done, cfgErr}), 64'(0));
    chk(busCsN == 4'hF, "R12 reset chip selects", 64'(busCsN), 64'hF);
    chk(busRdN && busWrN && !busAle && !busDataOe, "R12 reset strobes",
        64'({busRdN, busWrN, busAle, busDataOe}), 64'(4'b1100));
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && busCsN == 4'hF, "R12 idle after reset", 64'({busy, busCsN}), 64'(4'hF));

    // R2: first transfer after reset inserts turnaround
    runTxn(0, 1, 24'h12_3456, 16'h0, 0, 1, 2, 1, 1, 0, 3, 1, 0);
    // R2: same chip select, no turnaround
    runTxn(1, 1, 24'hAB_CDEF, 16'hBEEF, 0, 1, 3, 2, 0, 1, 2, 2, 0);
    // R2: chip select switch, turnaround of 3
    runTxn(1, 2, 24'h00_5A5A, 16'h1234, 0, 1, 3, 1, 2, 1, 1, 3, 0);
    // R7: shared lines, 16-bit read
    runTxn(0, 2, 24'hFF_C3A5, 16'h0, 1, 1, 1, 2, 1, 0, 2, 1, 0);
    // R7/R9: shared lines, 8-bit write
    runTxn(1, 3, 24'h01_77E4, 16'hA55A, 1, 0, 1, 1, 0, 1, 1, 0, 0);
    // R9: 8-bit read
    runTxn(0, 3, 24'h00_0100, 16'h0, 0, 0, 0, 1, 0, 0, 4, 0, 0);
    // R10: address phase 0 -> 1, strobe 0 -> 1
    runTxn(0, 0, 24'h33_3333, 16'h0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
    // R10: address phase 3 -> 2, setup 3 -> 1, strobe 63 -> 32
    runTxn(1, 0, 24'h44_4444, 16'hC0DE, 1, 1, 0, 3, 1, 3, 63, 2, 0);
    // R10: strobe exactly 32 is legal
    runTxn(0, 1, 24'h55_0055, 16'h0, 0, 1, 2, 2, 3, 1, 32, 3, 0);
    // R11: request during busy is ignored
    runTxn(1, 1, 24'h66_6006, 16'h9876, 0, 1, 1, 1, 1, 1, 2, 1, 1);
    runTxn(0, 2, 24'h77_7007, 16'h0, 1, 0, 3, 1, 0, 0, 5, 0, 1);

    for (int n = 0; n < 60; n++) begin
      runTxn(bit'($urandom_range(1)), int'($urandom_range(3)), 24'($urandom),
             16'($urandom), bit'($urandom_range(1)), bit'($urandom_range(1)),
             int'($urandom_range(3)), int'($urandom_range(3)), int'($urandom_range(3)),
             int'($urandom_range(3)), int'($urandom_range(40)), int'($urandom_range(3)),
             ($urandom_range(3) == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule